// File: doc/BRIEF.md
# Fault Snapshot and Alert Latch

This block sits beside a multi-rail power controller and keeps the evidence of its first abnormal event. The controller reports each event as a one-cycle strobe carrying the event kind, the fault category, the rail index and its own state. The measured voltage, current and temperature arrive as parallel digital codes. When the first warning or fault arrives while the block is armed, it freezes a record in the same clock cycle. The record holds a free-running timestamp, the event fields, the controller state and the three measured codes. The active-low alert output then goes low and stays low until a host releases it.

Once the record is frozen, later events cannot overwrite it. They only increment a saturating repeat counter. Bus timeout and retry pulses from the serial-bus side are counted as well, so that lost host visibility is recorded next to the fault. A host reads the record through a small register port. It may release the record only after it has read every snapshot word since the capture. A release attempted earlier is ignored and leaves a sticky error bit. A live status flag follows the controller state and clears by itself, while the frozen flag and the alert stay latched.

Top module: `fault_evidence_latch`

## Requirements
- R1: After reset, alert_n is 1, the status word (address 4) reads 0, and the counter word (address 5) reads 0.
- R2: An event strobe whose kind is warning (0) or fault (1), arriving while the block is armed, freezes a record. The record holds: word 0, the timestamp (cycles since reset release, taken in the strobe cycle); word 2, the I code in bits [23:12] and the V code in bits [11:0]; word 3, the T code in bits [11:0]. alert_n is 0 from the next cycle.
- R3: A strobe of kind clear (2) or the unused kind 3 arriving while the block is armed captures nothing, and alert_n stays 1.
- R4: While frozen, every further strobe of any kind leaves words 0 to 3 unchanged and increments the repeat count (address 5 bits [7:0]). The count saturates at 255.
- R5: Writing address 6 with bit 0 set releases the record only when all four snapshot words (addresses 0 to 3) have been read since the capture. The release sets alert_n to 1, clears the three counters and re-arms the capture. The same write while armed has no effect.
- R6: A release write made while frozen, before every snapshot word has been read, is ignored and sets the sticky clear-order error (status bit 1). Only a write to address 6 with bit 1 set clears that error.
- R7: Status bit 2 is 1 exactly while the ctl_state input is not normal (0). It clears by itself. alert_n and the frozen flag (status bit 0) stay latched whatever this flag does. Status bit 3 shows that all snapshot words have been read.
- R8: Each bus_timeout pulse increments address 5 bits [15:8] and each bus_retry pulse increments bits [23:16]. Both counts saturate at 255 and are cleared only by a release.
- R9: Word 1 holds rail in bits [1:0], event kind in [3:2], fault in [6:4] and controller state in [9:7]. The kinds are warning 0, fault 1, clear 2. The faults are undervoltage 0, overvoltage 1, overcurrent 2, overtemperature 3, short 4. The states are normal 0, ramp 1, fault-action 2, retry 3, latched 4. The rails are core 0, I/O 1, pump 2, management 3.
- R10: A read strobe on reg_rd presents the addressed word on reg_rdata after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle event strobe from the power controller |
| evt_kind | input | 2 | Event kind: warning, fault or clear |
| evt_fault | input | 3 | Fault category |
| evt_rail | input | 2 | Rail index |
| ctl_state | input | 3 | Current controller state |
| meas_v | input | CODE_W | Latest voltage code |
| meas_i | input | CODE_W | Latest current code |
| meas_t | input | CODE_W | Latest temperature code |
| bus_timeout | input | 1 | Bus timeout pulse |
| bus_retry | input | 1 | Bus retry pulse |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 2 | Command bits for address 6 |
| reg_rdata | output | 32 | Read data, registered |
| alert_n | output | 1 | Active-low latched alert |

## Verification
The bench builds the block with its default parameters: 12-bit measurement codes and 8-bit counters. With 8-bit counters, saturation of the repeat and bus counters takes only a few hundred strobes, so the bench drives each counter past 255 directly. The 12-bit codes fill a word-2 layout in which the current and voltage fields sit next to each other. A field misplaced in that layout therefore changes the value the host reads. Random rounds vary the read order of the snapshot words and mix early release attempts with later events, so that the read-order guard and the frozen record are checked against many interleavings.

// File: rtl/fel_pkg.sv
package fel_pkg;

  typedef enum logic [1:0] {
    EV_WARN  = 2'd0,
    EV_FAULT = 2'd1,
    EV_CLEAR = 2'd2,
    EV_RSVD  = 2'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    FT_UV    = 3'd0,
    FT_OV    = 3'd1,
    FT_OC    = 3'd2,
    FT_OT    = 3'd3,
    FT_SHORT = 3'd4
  } flt_e;

  typedef enum logic [2:0] {
    CS_NORMAL  = 3'd0,
    CS_RAMP    = 3'd1,
    CS_FACTION = 3'd2,
    CS_RETRY   = 3'd3,
    CS_LATCHED = 3'd4
  } cstate_e;

  typedef struct packed {
    logic [1:0] rail;
    ev_kind_e   kind;
    flt_e       fault;
    cstate_e    state;
  } ev_info_t;

  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 3;
  localparam int SNAP_WORDS = 4;

  localparam logic [ADDR_W-1:0] A_TS   = 3'd0;
  localparam logic [ADDR_W-1:0] A_INFO = 3'd1;
  localparam logic [ADDR_W-1:0] A_VI   = 3'd2;
  localparam logic [ADDR_W-1:0] A_T    = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd6;

  // R9 word layout: rail [1:0], kind [3:2], fault [6:4], state [9:7]
  function automatic logic [DATA_W-1:0] pack_info(input ev_info_t x);
    logic [DATA_W-1:0] w;
    w = '0;
    w[1:0] = x.rail;
    w[3:2] = x.kind;
    w[6:4] = x.fault;
    w[9:7] = x.state;
    return w;
  endfunction

  function automatic logic is_capturable(input ev_kind_e k);
    return (k == EV_WARN) || (k == EV_FAULT);
  endfunction

endpackage

// File: rtl/fel_timebase.sv
module fel_timebase #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] now
);

  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  a_r2_time_advances: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> now == $past(now) + 1'b1);

endmodule

// File: rtl/fel_sat_counter.sv
module fel_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] next_val(input logic [W-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= next_val(q);
  end

  // R4 and R8: a full counter never wraps to zero
  a_r8_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (&q && !clr) |=> &q);

  a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> q == '0);

endmodule

// File: rtl/fel_capture.sv
module fel_capture
  import fel_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  ev_info_t          evt_info,
  input  logic [CODE_W-1:0] v_code,
  input  logic [CODE_W-1:0] i_code,
  input  logic [CODE_W-1:0] t_code,
  input  logic [TS_W-1:0]   now,
  input  logic              release_ok,
  output logic              frozen,
  output logic              capture_evt,
  output logic              repeat_evt,
  output logic [TS_W-1:0]   snap_ts,
  output ev_info_t          snap_info,
  output logic [CODE_W-1:0] snap_v,
  output logic [CODE_W-1:0] snap_i,
  output logic [CODE_W-1:0] snap_t
);

  assign capture_evt = evt_valid && !frozen && is_capturable(evt_info.kind);
  assign repeat_evt  = evt_valid && frozen && !release_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frozen <= 1'b0;
    end else if (release_ok) begin
      frozen <= 1'b0;
    end else if (capture_evt) begin
      frozen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_ts   <= '0;
      snap_info <= '0;
      snap_v    <= '0;
      snap_i    <= '0;
      snap_t    <= '0;
    end else if (capture_evt) begin
      snap_ts   <= now;
      snap_info <= evt_info;
      snap_v    <= v_code;
      snap_i    <= i_code;
      snap_t    <= t_code;
    end
  end

  a_r2_capture_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> frozen && snap_v == $past(v_code) && snap_info == $past(evt_info));

  a_r3_clear_kind_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !frozen && evt_info.kind == EV_CLEAR) |=> !frozen);

  a_r4_record_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !release_ok) |=> frozen && $stable(snap_ts) && $stable(snap_info)
      && $stable(snap_v) && $stable(snap_i) && $stable(snap_t));

endmodule

// File: rtl/fel_clear_guard.sv
module fel_clear_guard
  import fel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frozen,
  input  logic              capture_evt,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rel_req,
  input  logic              err_clr_req,
  output logic              all_read,
  output logic              release_ok,
  output logic              release_bad,
  output logic              order_err
);

  localparam int IDX_W = $clog2(SNAP_WORDS);

  logic [SNAP_WORDS-1:0] read_mask;
  logic                  snap_hit;

  assign snap_hit    = rd_en && frozen && (rd_addr < ADDR_W'(SNAP_WORDS));
  assign all_read    = &read_mask;
  assign release_ok  = rel_req && frozen && all_read;
  assign release_bad = rel_req && frozen && !all_read;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      read_mask <= '0;
    end else if (capture_evt || release_ok) begin
      read_mask <= '0;
    end else if (snap_hit) begin
      read_mask[rd_addr[IDX_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           order_err <= 1'b0;
    else if (release_bad) order_err <= 1'b1;
    else if (err_clr_req) order_err <= 1'b0;
  end

  a_r6_bad_release_flags: assert property (@(posedge clk) disable iff (!rst_n)
    release_bad |=> order_err && frozen);

  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (order_err && !err_clr_req) |=> order_err);

  a_r5_fresh_mask: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> !all_read);

endmodule

// File: rtl/fault_evidence_latch.sv
module fault_evidence_latch
  import fel_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CNT_W  = 8,
  parameter int TS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [1:0]        evt_kind,
  input  logic [2:0]        evt_fault,
  input  logic [1:0]        evt_rail,
  input  logic [2:0]        ctl_state,
  input  logic [CODE_W-1:0] meas_v,
  input  logic [CODE_W-1:0] meas_i,
  input  logic [CODE_W-1:0] meas_t,
  input  logic              bus_timeout,
  input  logic              bus_retry,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [1:0]        reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              alert_n
);

  localparam int NCNT    = 3;
  localparam int C_REP   = 0;
  localparam int C_TMO   = 1;
  localparam int C_RTY   = 2;

  ev_info_t          evt_info;
  logic [TS_W-1:0]   now;
  logic              frozen;
  logic              capture_evt;
  logic              repeat_evt;
  logic              release_ok;
  logic              release_bad;
  logic              order_err;
  logic              all_read;
  logic              live_abn;
  logic              rel_req;
  logic              err_clr_req;
  logic [TS_W-1:0]   snap_ts;
  ev_info_t          snap_info;
  logic [CODE_W-1:0] snap_v;
  logic [CODE_W-1:0] snap_i;
  logic [CODE_W-1:0] snap_t;
  logic [NCNT-1:0]   cnt_inc;
  logic [CNT_W-1:0]  cnt_q [NCNT];

  function automatic logic [DATA_W-1:0] pack_status(input logic frz, input logic err,
                                                    input logic live, input logic done);
    return DATA_W'({done, live, err, frz});
  endfunction

  function automatic logic [DATA_W-1:0] pack_counts(input logic [CNT_W-1:0] rep,
                                                    input logic [CNT_W-1:0] tmo,
                                                    input logic [CNT_W-1:0] rty);
    return DATA_W'({rty, tmo, rep});
  endfunction

  assign evt_info.rail  = evt_rail;
  assign evt_info.kind  = ev_kind_e'(evt_kind);
  assign evt_info.fault = flt_e'(evt_fault);
  assign evt_info.state = cstate_e'(ctl_state);

  assign live_abn    = (ctl_state != CS_NORMAL);
  assign rel_req     = reg_wr && (reg_addr == A_CMD) && reg_wdata[0];
  assign err_clr_req = reg_wr && (reg_addr == A_CMD) && reg_wdata[1];

  fel_timebase #(.TS_W(TS_W)) u_time (
    .clk (clk),
    .rst_n (rst_n),
    .now (now)
  );

  fel_capture #(.CODE_W(CODE_W), .TS_W(TS_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_info    (evt_info),
    .v_code      (meas_v),
    .i_code      (meas_i),
    .t_code      (meas_t),
    .now         (now),
    .release_ok  (release_ok),
    .frozen      (frozen),
    .capture_evt (capture_evt),
    .repeat_evt  (repeat_evt),
    .snap_ts     (snap_ts),
    .snap_info   (snap_info),
    .snap_v      (snap_v),
    .snap_i      (snap_i),
    .snap_t      (snap_t)
  );

  fel_clear_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .frozen      (frozen),
    .capture_evt (capture_evt),
    .rd_en       (reg_rd),
    .rd_addr     (reg_addr),
    .rel_req     (rel_req),
    .err_clr_req (err_clr_req),
    .all_read    (all_read),
    .release_ok  (release_ok),
    .release_bad (release_bad),
    .order_err   (order_err)
  );

  assign cnt_inc[C_REP] = repeat_evt;
  assign cnt_inc[C_TMO] = bus_timeout;
  assign cnt_inc[C_RTY] = bus_retry;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    fel_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (release_ok),
      .inc   (cnt_inc[g]),
      .q     (cnt_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_TS:    reg_rdata <= DATA_W'(snap_ts);
        A_INFO:  reg_rdata <= pack_info(snap_info);
        A_VI:    reg_rdata <= DATA_W'({snap_i, snap_v});
        A_T:     reg_rdata <= DATA_W'(snap_t);
        A_STAT:  reg_rdata <= pack_status(frozen, order_err, live_abn, all_read);
        A_CNT:   reg_rdata <= pack_counts(cnt_q[C_REP], cnt_q[C_TMO], cnt_q[C_RTY]);
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign alert_n = !frozen;

  a_r2_alert_and_stamp: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> !alert_n && snap_ts == $past(now));

  a_r5_release_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    release_ok |=> alert_n);

  // R7: the latched alert ignores the auto-clearing live flag
  a_r7_alert_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n && !release_ok) |=> !alert_n);

  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_TS) |=> reg_rdata == $past(DATA_W'(snap_ts)));

endmodule

// File: tb/sim_fault_evidence_latch.sv
module sim_fault_evidence_latch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [1:0]  evt_kind = '0;
  logic [2:0]  evt_fault = '0;
  logic [1:0]  evt_rail = '0;
  logic [2:0]  ctl_state = '0;
  logic [11:0] meas_v = '0, meas_i = '0, meas_t = '0;
  logic        bus_timeout = 1'b0, bus_retry = 1'b0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [1:0]  reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        alert_n;

  int unsigned n_chk = 0, n_fail = 0;
  int unsigned bcyc = 0;
  bit          done = 0;

  // expected record
  logic [31:0] e_ts, e_info, e_vi, e_t;
  int unsigned e_rep, e_tmo, e_rty;
  bit          e_err;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) bcyc <= 0;
    else        bcyc <= bcyc + 1;
  end

  fault_evidence_latch u0 (
    .clk, .rst_n, .evt_valid, .evt_kind, .evt_fault, .evt_rail, .ctl_state,
    .meas_v, .meas_i, .meas_t, .bus_timeout, .bus_retry,
    .reg_rd, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .alert_n
  );

  function automatic logic [31:0] f_info(int r, int k, int f, int s);
    return 32'(r + k * 4 + f * 16 + s * 128);
  endfunction

  function automatic logic [31:0] f_stat(bit frz, bit err, bit live, bit done_rd);
    return 32'((done_rd ? 8 : 0) + (live ? 4 : 0) + (err ? 2 : 0) + (frz ? 1 : 0));
  endfunction

  function automatic int unsigned f_sat(int unsigned x);
    return (x > 255) ? 255 : x;
  endfunction

  function automatic logic [31:0] f_cnt(int unsigned rep, int unsigned tmo, int unsigned rty);
    return 32'(f_sat(rep) + f_sat(tmo) * 256 + f_sat(rty) * 65536);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic evt(input int k, input int f, input int r, input int s,
                     input int v, input int i, input int t, input bit expect_cap);
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = 2'(k); evt_fault = 3'(f); evt_rail = 2'(r);
    ctl_state = 3'(s); meas_v = 12'(v); meas_i = 12'(i); meas_t = 12'(t);
    if (expect_cap) begin
      e_ts = bcyc;
      e_info = f_info(r, k, f, s);
      e_vi = 32'(i * 4096 + v);
      e_t = 32'(t);
    end
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic pulse(input bit tmo, input bit rty);
    @(negedge clk);
    bus_timeout = tmo; bus_retry = rty;
    @(negedge clk);
    bus_timeout = 1'b0; bus_retry = 1'b0;
  endtask

  task automatic chk_word(input int w, input string tag);
    logic [31:0] d;
    rd(3'(w), d);
    case (w)
      0: chk(tag, d, e_ts);
      1: chk(tag, d, e_info);
      2: chk(tag, d, e_vi);
      default: chk(tag, d, e_t);
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 alert_n", 32'(alert_n), 32'd1);
    rd(3'd4, d); chk("R1 status", d, 32'd0);
    rd(3'd5, d); chk("R1 counters", d, 32'd0);

    // R3 clear kind and unused kind do not capture
    evt(2, 1, 1, 0, 5, 6, 7, 0);
    chk("R3 clear kind alert_n", 32'(alert_n), 32'd1);
    evt(3, 0, 0, 0, 5, 6, 7, 0);
    chk("R3 kind3 alert_n", 32'(alert_n), 32'd1);
    rd(3'd4, d); chk("R3 status", d, 32'd0);
    // R5 release while armed has no effect
    wr(2'b01);
    rd(3'd4, d); chk("R5 release armed status", d, 32'd0);

    // R2 directed capture: warning, pump rail, overtemperature, ramp state
    evt(0, 3, 2, 1, 12'hABC, 12'h123, 12'h456, 1);
    chk("R2 alert_n low", 32'(alert_n), 32'd0);
    rd(3'd4, d); chk("R7 live while ramp", d, f_stat(1, 0, 1, 0));
    ctl_state = 3'd0;
    rd(3'd4, d); chk("R7 live auto-clears", d, f_stat(1, 0, 0, 0));
    chk("R7 alert still low", 32'(alert_n), 32'd0);
    rd(3'd0, d); chk("R10 timestamp word", d, e_ts);
    chk_word(1, "R9 info word");
    chk_word(2, "R2 V/I word");
    // R6 early release
    wr(2'b01);
    chk("R6 early release ignored", 32'(alert_n), 32'd0);
    rd(3'd4, d); chk("R6 order error set", d, f_stat(1, 1, 0, 0));
    // R4 later events do not overwrite
    evt(1, 0, 0, 0, 1, 2, 3, 0);
    evt(1, 4, 3, 0, 9, 9, 9, 0);
    evt(2, 2, 1, 0, 7, 7, 7, 0);
    chk_word(3, "R2 T word");
    rd(3'd5, d); chk("R4 repeat count", d, f_cnt(3, 0, 0));
    for (int w = 0; w < 4; w++) chk_word(w, "R4 record unchanged");
    rd(3'd4, d); chk("R7 all-read bit", d, f_stat(1, 1, 0, 1));
    wr(2'b01);
    chk("R5 release alert_n", 32'(alert_n), 32'd1);
    rd(3'd5, d); chk("R5 counters cleared", d, 32'd0);
    rd(3'd4, d); chk("R6 error sticky after release", d, f_stat(0, 1, 0, 0));
    wr(2'b10);
    rd(3'd4, d); chk("R6 error cleared", d, 32'd0);

    // R4 and R8 saturation
    evt(1, 4, 0, 2, 100, 200, 300, 1);
    ctl_state = 3'd0;
    for (int n = 0; n < 260; n++) evt(n % 3, 1, 1, 0, n, n, n, 0);
    for (int n = 0; n < 300; n++) pulse(1, n < 5);
    rd(3'd5, d); chk("R4 R8 saturated counters", d, f_cnt(260, 300, 5));
    for (int w = 0; w < 4; w++) chk_word(w, "R4 record after flood");
    wr(2'b01);
    chk("R5 release after flood", 32'(alert_n), 32'd1);

    // random rounds
    for (int rnd = 0; rnd < 30; rnd++) begin
      int k, f, r, s, nx, st;
      bit early;
      k = int'($urandom % 2); f = int'($urandom % 5); r = int'($urandom % 4);
      s = int'($urandom % 5);
      evt(k, f, r, s, int'($urandom % 4096), int'($urandom % 4096),
          int'($urandom % 4096), 1);
      chk("R2 random capture alert_n", 32'(alert_n), 32'd0);
      e_rep = 0; e_tmo = 0; e_rty = 0; e_err = 0;
      nx = int'($urandom % 6);
      for (int n = 0; n < nx; n++) begin
        s = int'($urandom % 5);
        evt(int'($urandom % 4), int'($urandom % 5), int'($urandom % 4), s,
            int'($urandom % 4096), 1, 2, 0);
        e_rep++;
      end
      for (int n = 0; n < int'($urandom % 4); n++) begin
        bit a, b;
        a = 1'($urandom); b = 1'($urandom);
        pulse(a, b);
        e_tmo += a; e_rty += b;
      end
      st = int'($urandom % 4);
      early = 1'($urandom);
      for (int j = 0; j < 4; j++) begin
        if (j == 3 && early) begin
          wr(2'b01);
          e_err = 1;
          chk("R6 random early release", 32'(alert_n), 32'd0);
        end
        chk_word((st + j) % 4, "R4 random record");
      end
      rd(3'd4, d); chk("R7 random status", d, f_stat(1, e_err, s != 0, 1));
      rd(3'd5, d); chk("R8 random counters", d, f_cnt(e_rep, e_tmo, e_rty));
      wr(2'b11);
      chk("R5 random release", 32'(alert_n), 32'd1);
      rd(3'd4, d); chk("R6 random status after", d, f_stat(0, 0, s != 0, 0));
      ctl_state = 3'd0;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule